// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Source

This block streams a stored bitstream, one bit per clock edge, into the configuration input of an SRAM-based FPGA. Two inputs control it: an output-enable input that also clears the block while it is low, and an active-low select. A rising edge on the serial clock moves the bit pointer forward and puts the next stored bit on the data output. The data output is modelled as a value plus a drive enable, so several sources can share one line and a testbench can settle that line itself.

At the end of its power-on interval the block samples its select input. If the select is low, the block becomes the chain leader and makes the serial clock from the system clock. If the select is high, it becomes a follower and takes the serial clock as an input. Several blocks can be chained: the cascade output of one block drives the select of the next. When a block has sent its last bit, it stops driving the data line and pulls its cascade output low. The leader keeps clocking while its own select stays low. When its select is raised after the data is exhausted, it sends a fixed number of extra clocks and then goes idle.

Top module: `cfg_bitstream_src`

## Requirements
- R1: After reset is released, `ready_o` stays low for POR_CYCLES clocks and then stays high. While it is low, neither the data line nor the serial clock is driven.
- R2: The level of `cs_n_i` on the clock at which `ready_o` rises fixes the role. Low gives leader (`dclk_oe_o`=1). High gives follower (`dclk_oe_o`=0). The role holds until the next reset.
- R3: While `oe_i` is low, at any level of `cs_n_i`, the bit pointer is cleared, so that `casc_n_o`=1 and `done_o`=0 on the next clock. Data is not driven, and a leader holds `dclk_o` low. After `oe_i` returns high, the stream restarts from bit 0.
- R4: Stored bit k is on `data_o` while the pointer equals k, and bit 0 is sent first. The pointer moves up by exactly one per serial-clock rising edge, and only when `oe_i` is high, the select was low just before that edge, and the pointer is below DEPTH.
- R5: `data_oe_o` is high only while `oe_i` is high, `cs_n_i` is low and the pointer is below DEPTH. With `cs_n_i` high the block is in standby, and toggling `oe_i` drives nothing.
- R6: When the pointer reaches DEPTH, `casc_n_o` goes low, `done_o` goes high and the data line is released.
- R7: As leader, `dclk_o` toggles every DIV_HALF system clocks, so one serial-clock period is 2*DIV_HALF clocks. It runs while `oe_i` is high and `cs_n_i` is low, including after the block's own data is exhausted, so that followers downstream keep receiving clocks.
- R8: As leader, when `cs_n_i` goes high after the data is exhausted, exactly TRAIL_CLKS (16) further rising edges appear on `dclk_o`. After that `dclk_o` stays low until `oe_i` goes low.
- R9: As leader, when `cs_n_i` goes high before the data is exhausted, `dclk_o` stops low at once and no extra clocks follow.
- R10: As follower, the block counts rising serial-clock edges synchronised into the system clock domain. An edge on which its select falls is not counted. In a two-block chain the receiver sees the follower's bit 0 directly after the leader's last bit, and the two data enables are never high together.
- R11: A write with `wr_en_i`=1 stores `wr_bit_i` at `wr_addr_i`. That stored bit is the one later sent at that position of the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| oe_i | input | 1 | Output enable; low clears the bit pointer |
| cs_n_i | input | 1 | Active-low select; also sampled to pick the role |
| dclk_i | input | 1 | Serial clock input, used as follower |
| wr_en_i | input | 1 | Preload write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Preload bit address |
| wr_bit_i | input | 1 | Preload bit value |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Drive enable for the data line |
| dclk_o | output | 1 | Generated serial clock, used as leader |
| dclk_oe_o | output | 1 | High when this block drives the serial clock |
| casc_n_o | output | 1 | Active-low cascade output, low once all bits are sent |
| ready_o | output | 1 | Low during the power-on interval, high (released) afterwards |
| done_o | output | 1 | End-of-data flag, high while the pointer is at DEPTH |

## Verification
The leader's last counting edge, which also pulls its cascade output low, arrives at the follower in the same clock edge as the follower's select falling. The follower therefore has to tell apart an edge that belongs to the upstream device from the first edge that belongs to itself. The bench chains a leader and a follower on one resolved data line and provokes this on every full transfer. It passes judgment by checking that the bit taken at the first edge after the hand-over is the follower's bit 0, and that both enables are never high at once.

// File: rtl/cfg_src_pkg.sv
package cfg_src_pkg;

  // leader clock generator phases
  typedef enum logic [1:0] {
    MG_ACTIVE = 2'd0,
    MG_TRAIL  = 2'd1,
    MG_IDLE   = 2'd2
  } mclk_state_e;

  // serial clock period in system clocks for a given half-period count
  function automatic int unsigned clk_period(input int unsigned div_half);
    return 2 * div_half;
  endfunction

  // true when a pointer value has moved past every stored bit
  function automatic logic at_end(input int unsigned ptr, input int unsigned depth);
    return ptr >= depth;
  endfunction

  // next pointer value for one permitted advance
  function automatic int unsigned next_ptr(input int unsigned ptr, input int unsigned depth);
    return (ptr >= depth) ? depth : ptr + 1;
  endfunction

endpackage

// File: rtl/cfg_por_seq.sv
module cfg_por_seq #(
  parameter int POR_CYCLES = 8,
  localparam int PW = (POR_CYCLES < 2) ? 1 : $clog2(POR_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  output logic ready_o,
  output logic leader_o
);

  logic [PW-1:0] cnt_q;
  logic          ready_q;
  logic          leader_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ready_q  <= 1'b0;
      leader_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == PW'(POR_CYCLES - 1)) begin
        ready_q  <= 1'b1;
        leader_q <= !cs_n_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ready_o  = ready_q;
  assign leader_o = leader_q;

endmodule

// File: rtl/cfg_mclk_gen.sv
module cfg_mclk_gen
  import cfg_src_pkg::*;
#(
  parameter int DIV_HALF   = 4,
  parameter int TRAIL_CLKS = 16,
  localparam int HW = $clog2(DIV_HALF + 1),
  localparam int TW = $clog2(TRAIL_CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic oe_i,
  input  logic cs_n_i,
  input  logic exhausted_i,
  output logic dclk_o,
  output logic rise_o,
  output logic idle_o,
  output logic trail_o
);

  mclk_state_e   st_q;
  logic [HW-1:0] hcnt_q;
  logic [TW-1:0] tcnt_q;
  logic          dclk_q;
  logic          run;
  logic          tick;
  logic          fall;

  assign run  = en_i && oe_i &&
                (((st_q == MG_ACTIVE) && !cs_n_i) || (st_q == MG_TRAIL));
  assign tick = run && (hcnt_q == HW'(DIV_HALF - 1));
  assign rise_o = tick && !dclk_q;
  assign fall   = tick && dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MG_ACTIVE;
      hcnt_q <= '0;
      tcnt_q <= '0;
      dclk_q <= 1'b0;
    end else if (!en_i || !oe_i) begin
      st_q   <= MG_ACTIVE;
      hcnt_q <= '0;
      tcnt_q <= '0;
      dclk_q <= 1'b0;
    end else begin
      case (st_q)
        MG_ACTIVE: begin
          if (cs_n_i && exhausted_i) begin
            st_q   <= MG_TRAIL;
            tcnt_q <= '0;
          end
        end
        MG_TRAIL: begin
          if (rise_o) tcnt_q <= tcnt_q + 1'b1;
          if (fall && (tcnt_q == TW'(TRAIL_CLKS))) st_q <= MG_IDLE;
        end
        default: st_q <= MG_IDLE;
      endcase
      if (run) begin
        if (tick) begin
          hcnt_q <= '0;
          dclk_q <= !dclk_q;
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end else begin
        hcnt_q <= '0;
        dclk_q <= 1'b0;
      end
    end
  end

  assign dclk_o  = dclk_q;
  assign idle_o  = (st_q == MG_IDLE);
  assign trail_o = (st_q == MG_TRAIL);

endmodule

// File: rtl/cfg_slv_edge.sv
module cfg_slv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk_i,
  input  logic cs_n_i,
  output logic rise_ok_o
);

  // clock and select travel through matched stages
  logic [2:0] clk_pipe_q;
  logic [2:0] sel_pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe_q <= '0;
      sel_pipe_q <= '1;
    end else begin
      clk_pipe_q <= {clk_pipe_q[1:0], dclk_i};
      sel_pipe_q <= {sel_pipe_q[1:0], cs_n_i};
    end
  end

  // the select level seen before the edge decides whether it counts
  assign rise_ok_o = clk_pipe_q[1] && !clk_pipe_q[2] && !sel_pipe_q[2];

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  input  logic [CW-1:0] rd_addr_i,
  output logic          rd_bit_o
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (wr_en_i && (int'(wr_addr_i) < DEPTH)) bits_q[wr_addr_i] <= wr_bit_i;
  end

  assign rd_bit_o = (int'(rd_addr_i) < DEPTH) ? bits_q[rd_addr_i[AW-1:0]] : 1'b0;

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
  import cfg_src_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live_i,
  input  logic          oe_i,
  input  logic          step_i,
  output logic [CW-1:0] addr_o,
  output logic          exhausted_o
);

  logic [CW-1:0] addr_q;

  assign exhausted_o = at_end(int'(addr_q), DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (!live_i || !oe_i) begin
      addr_q <= '0;
    end else if (step_i && !exhausted_o) begin
      addr_q <= CW'(next_ptr(int'(addr_q), DEPTH));
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/cfg_bitstream_src.sv
module cfg_bitstream_src #(
  parameter int DEPTH      = 64,
  parameter int DIV_HALF   = 4,
  parameter int TRAIL_CLKS = 16,
  parameter int POR_CYCLES = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_i,
  input  logic          cs_n_i,
  input  logic          dclk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic          wr_bit_i,
  output logic          data_o,
  output logic          data_oe_o,
  output logic          dclk_o,
  output logic          dclk_oe_o,
  output logic          casc_n_o,
  output logic          ready_o,
  output logic          done_o
);

  // named internal events, also watched by the checker
  logic          por_ready;
  logic          is_leader;
  logic          gen_en;
  logic          gen_dclk;
  logic          gen_rise;
  logic          gen_idle;
  logic          gen_trail;
  logic          fol_rise;
  logic          adv_step;
  logic          exhausted;
  logic [CW-1:0] cur_addr;
  logic          cur_bit;

  cfg_por_seq #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_i   (cs_n_i),
    .ready_o  (por_ready),
    .leader_o (is_leader)
  );

  assign gen_en = por_ready && is_leader;

  cfg_mclk_gen #(.DIV_HALF(DIV_HALF), .TRAIL_CLKS(TRAIL_CLKS)) u_mclk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (gen_en),
    .oe_i        (oe_i),
    .cs_n_i      (cs_n_i),
    .exhausted_i (exhausted),
    .dclk_o      (gen_dclk),
    .rise_o      (gen_rise),
    .idle_o      (gen_idle),
    .trail_o     (gen_trail)
  );

  cfg_slv_edge u_fol (
    .clk       (clk),
    .rst_n     (rst_n),
    .dclk_i    (dclk_i),
    .cs_n_i    (cs_n_i),
    .rise_ok_o (fol_rise)
  );

  assign adv_step = por_ready && (is_leader ? gen_rise : fol_rise);

  cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk         (clk),
    .rst_n       (rst_n),
    .live_i      (por_ready),
    .oe_i        (oe_i),
    .step_i      (adv_step),
    .addr_o      (cur_addr),
    .exhausted_o (exhausted)
  );

  cfg_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bit_i  (wr_bit_i),
    .rd_addr_i (cur_addr),
    .rd_bit_o  (cur_bit)
  );

  assign data_oe_o = por_ready && oe_i && !cs_n_i && !exhausted;
  assign data_o    = data_oe_o ? cur_bit : 1'b0;
  assign dclk_oe_o = gen_en;
  assign dclk_o    = gen_en ? gen_dclk : 1'b0;
  assign casc_n_o  = !exhausted;
  assign done_o    = exhausted;
  assign ready_o   = por_ready;

endmodule

// File: rtl/cfg_src_chk.sv
module cfg_src_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          oe_i,
  input logic          cs_n_i,
  input logic          data_oe_o,
  input logic          dclk_o,
  input logic          dclk_oe_o,
  input logic          casc_n_o,
  input logic          ready_o,
  input logic          done_o,
  input logic [CW-1:0] cur_addr,
  input logic          adv_step,
  input logic          gen_idle,
  input logic          gen_trail
);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  // R1
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (!data_oe_o && !dclk_oe_o));

  // R2
  role_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && $past(ready_o)) |-> $stable(dclk_oe_o));

  // R3
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |=> (cur_addr == '0));

  // R3
  leader_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dclk_oe_o) && !$past(oe_i)) |-> !dclk_o);

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_addr != $past(cur_addr)) |->
      ((cur_addr == $past(cur_addr) + 1'b1) || (cur_addr == '0)));

  // R4
  step_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe_i) && $past(ready_o) && (cur_addr != $past(cur_addr))) |-> $past(adv_step));

  // R5
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_i |-> !data_oe_o);

  // R6
  exhaust_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_n_o |-> (!data_oe_o && done_o));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_idle |-> !dclk_o);

  // R8
  trail_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gen_trail |-> done_o);

endmodule

bind cfg_bitstream_src cfg_src_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .oe_i      (oe_i),
  .cs_n_i    (cs_n_i),
  .data_oe_o (data_oe_o),
  .dclk_o    (dclk_o),
  .dclk_oe_o (dclk_oe_o),
  .casc_n_o  (casc_n_o),
  .ready_o   (ready_o),
  .done_o    (done_o),
  .cur_addr  (cur_addr),
  .adv_step  (adv_step),
  .gen_idle  (gen_idle),
  .gen_trail (gen_trail)
);

// File: tb/cfg_bitstream_src_tb.sv
`timescale 1ns/1ps
module cfg_bitstream_src_tb;

  localparam int D    = 64;
  localparam int DIVH = 4;
  localparam int TRL  = 16;
  localparam int PORC = 8;
  localparam int AW   = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oe = 1'b0;
  logic m_cs_n = 1'b0;
  logic m_wr_en = 1'b0, s_wr_en = 1'b0;
  logic [AW-1:0] m_wr_addr = '0, s_wr_addr = '0;
  logic m_wr_bit = 1'b0, s_wr_bit = 1'b0;

  logic m_data, m_doe, m_dclk, m_dclk_oe, m_casc_n, m_ready, m_done;
  logic s_data, s_doe, s_dclk, s_dclk_oe, s_casc_n, s_ready, s_done;

  always #2 clk = !clk;

  cfg_bitstream_src #(.DEPTH(D), .DIV_HALF(DIVH), .TRAIL_CLKS(TRL), .POR_CYCLES(PORC)) u_dut (
    .clk(clk), .rst_n(rst_n), .oe_i(oe), .cs_n_i(m_cs_n), .dclk_i(1'b0),
    .wr_en_i(m_wr_en), .wr_addr_i(m_wr_addr), .wr_bit_i(m_wr_bit),
    .data_o(m_data), .data_oe_o(m_doe), .dclk_o(m_dclk), .dclk_oe_o(m_dclk_oe),
    .casc_n_o(m_casc_n), .ready_o(m_ready), .done_o(m_done));

  cfg_bitstream_src #(.DEPTH(D), .DIV_HALF(DIVH), .TRAIL_CLKS(TRL), .POR_CYCLES(PORC)) u_slv (
    .clk(clk), .rst_n(rst_n), .oe_i(oe), .cs_n_i(m_casc_n), .dclk_i(m_dclk),
    .wr_en_i(s_wr_en), .wr_addr_i(s_wr_addr), .wr_bit_i(s_wr_bit),
    .data_o(s_data), .data_oe_o(s_doe), .dclk_o(s_dclk), .dclk_oe_o(s_dclk_oe),
    .casc_n_o(s_casc_n), .ready_o(s_ready), .done_o(s_done));

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mm[D];
  bit sm[D];
  bit rx_val[1024];
  bit rx_drv[1024];
  int rx_n = 0;
  int cyc = 0;
  int last_rise = -1;
  int interval = 0;
  int contention = 0;
  logic prev_dclk = 1'b0;
  logic prev_val = 1'b0;
  logic prev_drv = 1'b0;

  function automatic bit exp_stream(input int idx);
    return (idx < D) ? mm[idx] : sm[idx - D];
  endfunction

  function automatic int exp_period(input int half);
    return half + half;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // receiver model: take the bus value seen just before each rising edge
  always @(negedge clk) begin
    if (m_doe && s_doe) contention++;
    if (m_dclk && !prev_dclk) begin
      if (rx_n < 1024) begin
        rx_val[rx_n] = prev_val;
        rx_drv[rx_n] = prev_drv;
      end
      rx_n++;
      if (last_rise >= 0) interval = cyc - last_rise;
      last_rise = cyc;
    end
    prev_dclk = m_dclk;
    prev_drv  = m_doe || s_doe;
    prev_val  = m_doe ? m_data : s_data;
    cyc++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rx(input int target);
    while (rx_n < target) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired act=%0d exp=%0d", rx_n, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    int snap;
    int abort_at;
    void'($urandom(32'h1b2c3d));
    for (int i = 0; i < D; i++) begin
      mm[i] = 1'($urandom);
      sm[i] = 1'($urandom);
    end
    // directed corner bits at both ends of each store
    mm[0] = 1'b1; mm[D-1] = 1'b1; sm[0] = 1'b1; sm[D-1] = 1'b0;

    step(5);
    chk(!m_ready && !m_doe && !m_dclk_oe, "R1", "quiet in reset", int'(m_ready), 0);
    rst_n = 1'b1;
    step(3);
    chk(!m_ready && !s_ready, "R1", "ready low in power-on interval", int'(m_ready), 0);
    chk(!m_dclk_oe && !m_doe, "R1", "nothing driven before ready", int'(m_dclk_oe), 0);
    step(PORC + 2);
    chk(m_ready && s_ready, "R1", "ready released", int'(m_ready), 1);
    chk(m_dclk_oe == 1'b1, "R2", "leader drives clock", int'(m_dclk_oe), 1);
    chk(s_dclk_oe == 1'b0, "R2", "follower leaves clock", int'(s_dclk_oe), 0);

    // R11 preload through the write port while oe is low
    for (int i = 0; i < D; i++) begin
      m_wr_en = 1'b1; m_wr_addr = AW'(i); m_wr_bit = mm[i];
      s_wr_en = 1'b1; s_wr_addr = AW'(i); s_wr_bit = sm[i];
      step(1);
    end
    m_wr_en = 1'b0; s_wr_en = 1'b0;
    step(2);
    chk(!m_dclk && !m_doe && !s_doe && rx_n == 0, "R3", "oe low holds everything", rx_n, 0);

    // full chained transfer
    oe = 1'b1;
    wait_rx(2 * D);
    m_cs_n = 1'b1;
    chk(contention == 0, "R10", "no double drive", contention, 0);
    chk(interval == exp_period(DIVH), "R7", "serial clock period", interval, exp_period(DIVH));
    for (int i = 0; i < 2 * D; i++)
      chk(rx_drv[i] && rx_val[i] == exp_stream(i), "R4 R11", $sformatf("stream bit %0d", i),
          int'(rx_val[i]), int'(exp_stream(i)));
    chk(rx_val[D] == sm[0], "R10", "follower bit 0 after hand-over", int'(rx_val[D]), int'(sm[0]));
    chk(rx_val[D-1] == mm[D-1], "R7", "clocks continue past leader end", int'(rx_val[D-1]), int'(mm[D-1]));
    step(exp_period(DIVH) * TRL + 40);
    chk(rx_n == 2 * D + TRL, "R8", "trailing clock count", rx_n - 2 * D, TRL);
    chk(!m_dclk, "R8", "clock low after trailing", int'(m_dclk), 0);
    chk(!m_casc_n && m_done && !s_casc_n && s_done, "R6", "cascade low at end", int'(m_casc_n), 0);
    chk(!m_doe && !s_doe, "R6", "data released at end", int'(m_doe), 0);
    snap = rx_n;
    step(100);
    chk(rx_n == snap && !m_dclk, "R8", "idle stays quiet", rx_n, snap);

    // oe low clears even with select high
    oe = 1'b0;
    step(2);
    chk(m_casc_n && !m_done && s_casc_n, "R3", "pointer cleared by oe", int'(m_casc_n), 1);
    chk(!m_doe && !s_doe && !m_dclk, "R3", "released while oe low", int'(m_doe), 0);

    // standby: select high, oe toggling
    oe = 1'b1;
    snap = rx_n;
    for (int k = 0; k < 4; k++) begin
      step(10);
      chk(!m_doe && !s_doe, "R5", "standby drives nothing", int'(m_doe), 0);
      oe = !oe;
    end
    oe = 1'b1;
    step(5);
    chk(rx_n == snap && !m_dclk, "R5", "no clock in standby", rx_n, snap);

    // early abort at a random point
    base = rx_n;
    abort_at = 3 + int'($urandom % (D - 6));
    m_cs_n = 1'b0;
    wait_rx(base + abort_at);
    m_cs_n = 1'b1;
    for (int i = 0; i < abort_at; i++)
      chk(rx_val[base + i] == mm[i], "R4", $sformatf("restart bit %0d", i),
          int'(rx_val[base + i]), int'(mm[i]));
    step(100);
    chk(rx_n == base + abort_at, "R9", "no trailing after early stop", rx_n - base, abort_at);
    chk(!m_dclk && !m_doe && m_casc_n, "R9", "clock low, data released", int'(m_dclk), 0);

    // short oe pulses restart from bit 0
    for (int r = 0; r < 3; r++) begin
      int k;
      k = 2 + int'($urandom % 5);
      oe = 1'b0;
      step(1 + int'($urandom % 3));
      chk(m_casc_n && !m_done, "R3", "pulse clears pointer", int'(m_casc_n), 1);
      oe = 1'b1;
      base = rx_n;
      m_cs_n = 1'b0;
      wait_rx(base + k);
      m_cs_n = 1'b1;
      for (int i = 0; i < k; i++)
        chk(rx_val[base + i] == mm[i], "R3", $sformatf("pulse restart bit %0d", i),
            int'(rx_val[base + i]), int'(mm[i]));
      step(20);
    end
    chk(contention == 0, "R10", "no double drive overall", contention, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule